// File: doc/BRIEF.md
# Lock-qualified reset synchronizer

This block generates the reset for logic that runs on a derived clock, for example a clock manager output at one quarter of the master frequency. The reset goes active at once, with no clock edge needed, whenever the external reset is high or the clock manager says it has not locked. It goes inactive only on a rising edge of the derived clock, and only after a fixed number of those edges.

The release path has three parts. First, an optional delay line lets the lock flag settle for a set number of derived-clock edges before it counts as valid. Second, a preset shift chain guarantees the minimum reset width. Third, a small counter adds a further number of cycles, chosen at run time by a stretch setting. If the lock flag or the external reset becomes active again at any point, all three parts restart.

Top module: `lqr_reset_sync`

## Requirements
- R1: With `ext_rst_i` high, `rst_o` is high within the same clock period, including when the derived clock is stopped.
- R2: With `lock_i` low, `rst_o` is high within the same clock period, including when the derived clock is stopped.
- R3: While `ext_rst_i` is high or `lock_i` is low, `rst_o` stays high across every clock edge.
- R4: Suppose both conditions have cleared and stay clear. Counting the derived-clock rising edges from that moment, `rst_o` is high after each of the first LOCK_DLY + CHAIN_LEN + `hold_extra_i` edges. It is low after the next edge and stays low from then on.
- R5: `rst_o` falls only at a rising edge of `clk_div_i`. Between edges it keeps the value it took at the last edge.
- R6: `hold_extra_i` is an unsigned count from 0 to 2^HOLD_W-1. Each unit adds one derived-clock cycle to the release in R4. It must be held stable while `rst_o` is high.
- R7: A drop of `lock_i` after release raises `rst_o` at once. A lock pulse that drops partway through the lock delay restarts the delay. In both cases the full edge count of R4 applies again, measured from the moment lock returns.
- R8: An external reset pulse shorter than one clock period, placed between two edges, still produces the full release sequence of R4.
- R9: With LOCK_DLY = 0 the delay line is bypassed, and release takes CHAIN_LEN + `hold_extra_i` + 1 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_div_i | input | 1 | Derived clock of the domain being reset |
| ext_rst_i | input | 1 | External reset request, active high, asynchronous |
| lock_i | input | 1 | Clock manager lock flag, high when locked, asynchronous |
| hold_extra_i | input | HOLD_W | Additional release cycles, unsigned |
| rst_o | output | 1 | Reset for the derived-clock domain, active high |

## Verification
The bench builds two instances that share their inputs. The first uses LOCK_DLY = 4, CHAIN_LEN = 3 and HOLD_W = 2. The second uses LOCK_DLY = 0, CHAIN_LEN = 2 and HOLD_W = 2, so both the delayed variant and the bypass variant are exercised together. Because HOLD_W is only 2, every stretch value from 0 to 3 can be swept. Release lengths of 3 to 11 edges are short enough to check the output after every edge and at mid-cycle. The clock can be gated off, which shows that assertion needs no clock and that release does not start until edges arrive.

// File: rtl/lqr_pkg.sv
package lqr_pkg;

   // Limits checked at elaboration by the top module.
   localparam int unsigned LQR_LOCK_DLY_MAX = 16;
   localparam int unsigned LQR_CHAIN_MIN    = 2;
   localparam int unsigned LQR_HOLD_W_MAX   = 8;

   // Number of derived-clock edges from the moment both conditions clear
   // to the edge that drops the output.
   function automatic int unsigned lqr_release_edges(input int unsigned dly,
                                                     input int unsigned len,
                                                     input int unsigned hold);
      return dly + len + hold + 1;
   endfunction

endpackage

// File: rtl/lqr_lock_delay.sv
// Qualifies the lock flag: it counts as valid only after DEPTH derived-clock
// edges with the raw condition clear. Cleared asynchronously by that condition.
module lqr_lock_delay #(
   parameter int unsigned DEPTH = 4
) (
   input  logic clk_i,
   input  logic arst_i,
   output logic ok_o
);

   if (DEPTH == 0) begin : g_bypass
      logic unused_in;
      assign unused_in = clk_i ^ arst_i;
      assign ok_o      = 1'b1;
   end else begin : g_line
      logic [DEPTH-1:0] dly_q;

      if (DEPTH == 1) begin : g_one
         always_ff @(posedge clk_i or posedge arst_i) begin
            if (arst_i) dly_q <= '0;
            else        dly_q <= 1'b1;
         end
      end else begin : g_many
         always_ff @(posedge clk_i or posedge arst_i) begin
            if (arst_i) dly_q <= '0;
            else        dly_q <= {dly_q[DEPTH-2:0], 1'b1};
         end
      end

      assign ok_o = dly_q[DEPTH-1];

      // Sampled mid-cycle, away from the edge that moves the line.
      always @(negedge clk_i) begin
         if (ok_o) begin
            assert_lock_gate_R7: assert (!arst_i)
               else $error("lock qualified while raw condition active");
         end
      end
   end

endmodule

// File: rtl/lqr_preset_chain.sv
// Shift chain preset by the combined condition; zeros enter from a constant.
module lqr_preset_chain #(
   parameter int unsigned LEN = 3
) (
   input  logic clk_i,
   input  logic arst_i,
   output logic tail_o
);

   logic [LEN-1:0] stg_q;

   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i) stg_q <= '1;
      else        stg_q <= {stg_q[LEN-2:0], 1'b0};
   end

   assign tail_o = stg_q[LEN-1];

   always @(negedge clk_i) begin
      if (!arst_i && !tail_o) begin
         assert_chain_in_order_R4: assert (stg_q == '0)
            else $error("chain tail released before earlier stages");
      end
   end

endmodule

// File: rtl/lqr_hold_stretch.sv
// Adds a run-time number of cycles after the chain releases, then drops the
// output flop. The output stays low until the next asynchronous preset.
module lqr_hold_stretch #(
   parameter int unsigned W = 2
) (
   input  logic         clk_i,
   input  logic         arst_i,
   input  logic         tail_i,
   input  logic [W-1:0] hold_i,
   output logic         rst_o
);

   logic [W-1:0] cnt_q;
   logic         rst_q;
   logic         done;

   assign done = !tail_i && (cnt_q == hold_i);

   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i) begin
         cnt_q <= '0;
         rst_q <= 1'b1;
      end else begin
         if (rst_q && !tail_i && !done) cnt_q <= cnt_q + W'(1);
         rst_q <= rst_q & ~done;
      end
   end

   assign rst_o = rst_q;

   always @(negedge clk_i) begin
      if (!arst_i && !rst_q) begin
         assert_out_after_chain_R5: assert (!tail_i)
            else $error("output released while chain still active");
      end
      if (!arst_i && rst_q) begin
         assert_cnt_bounded_R6: assert (cnt_q <= hold_i)
            else $error("stretch count beyond setting");
      end
   end

endmodule

// File: rtl/lqr_reset_sync.sv
module lqr_reset_sync
   import lqr_pkg::*;
#(
   parameter int unsigned LOCK_DLY  = 4,
   parameter int unsigned CHAIN_LEN = 3,
   parameter int unsigned HOLD_W    = 2
) (
   input  logic              clk_div_i,
   input  logic              ext_rst_i,
   input  logic              lock_i,
   input  logic [HOLD_W-1:0] hold_extra_i,
   output logic              rst_o
);

   if (LOCK_DLY > LQR_LOCK_DLY_MAX) begin : g_chk_dly
      $error("LOCK_DLY exceeds limit");
   end
   if (CHAIN_LEN < LQR_CHAIN_MIN) begin : g_chk_len
      $error("CHAIN_LEN below minimum");
   end
   if (HOLD_W < 1 || HOLD_W > LQR_HOLD_W_MAX) begin : g_chk_w
      $error("HOLD_W out of range");
   end

   logic raw_cond;
   logic lock_ok;
   logic comb_cond;
   logic tail;

   assign raw_cond = ext_rst_i | ~lock_i;

   lqr_lock_delay #(.DEPTH(LOCK_DLY)) u_dly (
      .clk_i  (clk_div_i),
      .arst_i (raw_cond),
      .ok_o   (lock_ok)
   );

   assign comb_cond = raw_cond | ~lock_ok;

   lqr_preset_chain #(.LEN(CHAIN_LEN)) u_chain (
      .clk_i  (clk_div_i),
      .arst_i (comb_cond),
      .tail_o (tail)
   );

   lqr_hold_stretch #(.W(HOLD_W)) u_hold (
      .clk_i  (clk_div_i),
      .arst_i (comb_cond),
      .tail_i (tail),
      .hold_i (hold_extra_i),
      .rst_o  (rst_o)
   );

   always @(negedge clk_div_i) begin
      if (raw_cond) begin
         assert_hold_while_cond_R3: assert (rst_o)
            else $error("reset output low while a condition is active");
      end
   end

endmodule

// File: tb/tb_lqr_reset_sync.sv
`timescale 1ns/1ps
module tb_lqr_reset_sync;

   logic       clk = 1'b0;
   logic       clk_run = 1'b0;
   logic       ext_rst = 1'b0;
   logic       lock = 1'b1;
   logic [1:0] hold = 2'd0;
   logic       rst_a, rst_b;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         done = 1'b0;

   // Delayed variant: LOCK_DLY 4, CHAIN_LEN 3 -> edges 8 + hold.
   lqr_reset_sync #(.LOCK_DLY(4), .CHAIN_LEN(3), .HOLD_W(2)) dut (
      .clk_div_i(clk), .ext_rst_i(ext_rst), .lock_i(lock),
      .hold_extra_i(hold), .rst_o(rst_a));

   // Bypass variant: LOCK_DLY 0, CHAIN_LEN 2 -> edges 3 + hold.
   lqr_reset_sync #(.LOCK_DLY(0), .CHAIN_LEN(2), .HOLD_W(2)) dut_nodly (
      .clk_div_i(clk), .ext_rst_i(ext_rst), .lock_i(lock),
      .hold_extra_i(hold), .rst_o(rst_b));

   // 50 MHz, gateable (stops with clk low).
   initial forever begin
      #10;
      if (clk_run) clk = ~clk;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Counts edges from now; checks after each edge and at mid-cycle.
   task automatic count_release(input string req, input int ea, input int eb);
      int last = (ea > eb ? ea : eb) + 2;
      for (int k = 1; k <= last; k++) begin
         @(posedge clk); #1;
         check({req, " dut edge"}, rst_a, (k < ea) ? 1 : 0);
         check({req, " nodly edge R9"}, rst_b, (k < eb) ? 1 : 0);
         #8;
         check({req, " dut mid R5"}, rst_a, (k < ea) ? 1 : 0);
         check({req, " nodly mid R5"}, rst_b, (k < eb) ? 1 : 0);
      end
   endtask

   task automatic drive_slot;
      @(negedge clk); #2;
   endtask

   initial begin
      #1 ext_rst = 1'b1;
      #4;
      check("R1 no clock dut", rst_a, 1);
      check("R1 no clock nodly", rst_b, 1);
      ext_rst = 1'b0;
      #30;
      check("R4 no edges no release dut", rst_a, 1);
      check("R4 no edges no release nodly", rst_b, 1);
      clk_run = 1'b1;
      count_release("R4 first", 8, 3);

      // R6: sweep every stretch value on both variants.
      for (int h = 0; h < 4; h++) begin
         drive_slot();
         ext_rst = 1'b1;
         hold = 2'(h);
         #3;
         check("R1 running dut", rst_a, 1);
         check("R1 running nodly", rst_b, 1);
         repeat (2) @(posedge clk);
         #1;
         check("R3 held dut", rst_a, 1);
         check("R3 held nodly", rst_b, 1);
         drive_slot();
         ext_rst = 1'b0;
         count_release("R6 sweep", 8 + h, 3 + h);
      end

      // R7: lock drop after release.
      drive_slot();
      lock = 1'b0;
      hold = 2'd1;
      #1;
      check("R2 R7 immediate dut", rst_a, 1);
      check("R2 R7 immediate nodly", rst_b, 1);
      repeat (3) @(posedge clk);
      drive_slot();
      lock = 1'b1;
      count_release("R7 relock", 9, 4);

      // R7: lock glitch partway through the lock delay.
      drive_slot();
      lock = 1'b0;
      drive_slot();
      lock = 1'b1;
      repeat (2) @(posedge clk);
      drive_slot();
      lock = 1'b0;
      #2;
      check("R7 glitch dut", rst_a, 1);
      check("R7 glitch nodly", rst_b, 1);
      #2 lock = 1'b1;
      count_release("R7 glitch restart", 9, 4);

      // R8: short external pulse between edges.
      hold = 2'd0;
      drive_slot();
      ext_rst = 1'b1;
      #2;
      check("R8 pulse dut", rst_a, 1);
      check("R8 pulse nodly", rst_b, 1);
      #2 ext_rst = 1'b0;
      count_release("R8 short pulse", 8, 3);

      // R2: lock low with the clock stopped.
      @(negedge clk);
      clk_run = 1'b0;
      #5 lock = 1'b0;
      #3;
      check("R2 no clock dut", rst_a, 1);
      check("R2 no clock nodly", rst_b, 1);
      lock = 1'b1;
      #40;
      check("R4 stopped dut", rst_a, 1);
      check("R4 stopped nodly", rst_b, 1);
      clk_run = 1'b1;
      count_release("R4 restart", 8, 3);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule